// File: doc/BRIEF.md
# Data-Processing ALU with NZCV Flag Register

This block is the integer data-processing unit of a 32-bit core. Each cycle it takes a 4-bit operation code, a first operand, and a second operand that an upstream shifter has already processed, together with that shifter's carry-out. It produces a combinational result, a write-enable for the destination register, and the next value of a four-bit Negative/Zero/Carry/oVerflow flag set. The flag set is held in a register inside the block. Its carry bit feeds the carry-using operations.

Flag updates follow two rules. A set-flags input decides whether ordinary operations change the flags. The four flag-only operations (test, test-equal, compare, compare-negated) always change the flags and never assert the write-enable. Logical operations take their carry from the shifter and keep the old overflow bit.

Top module: `dp_alu`

## Requirements
- R1: Arithmetic results, with op_i codes given in decimal: 4 ADD a+b, 5 ADC a+b+C, 2 SUB a-b, 6 SBC a-b+C-1, 3 RSB b-a, 7 RSC b-a+C-1, 10 CMP a-b, 11 CMN a+b. C is the stored carry flag and every result is taken modulo 2^WIDTH.
- R2: Logical results: 0 AND a&b, 8 TST a&b, 1 EOR a^b, 9 TEQ a^b, 12 ORR a|b, 13 MOV b, 14 BIC a&~b, 15 MVN ~b.
- R3: wr_en_o is 0 for codes 8 to 11 and 1 for all other codes.
- R4: When set_flags_i is 0 and the code is not in 8 to 11, flags_nxt_o equals flags_o.
- R5: When flags update, N (bit 3) equals the result MSB and Z (bit 2) is 1 exactly when the result is zero.
- R6: For arithmetic codes, C (bit 1) is the adder carry-out. For subtracting forms this means C is 1 when no borrow occurs.
- R7: For logical codes, an updated C equals shift_c_i.
- R8: For arithmetic codes, an updated V (bit 0) is 1 exactly when the signed result is out of range.
- R9: For logical codes, V keeps its stored value.
- R10: Codes 8 to 11 update the flags whatever the value of set_flags_i.
- R11: Reset clears flags_o to 0. On a clock edge with en_i at 1, flags_o takes the value of flags_nxt_o. With en_i at 0, flags_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Commits flags_nxt_o to the flag register |
| op_i | input | 4 | Operation code |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Shifted second operand |
| shift_c_i | input | 1 | Shifter carry-out |
| set_flags_i | input | 1 | Enables flag update for ordinary operations |
| result_o | output | WIDTH | Operation result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |
| flags_nxt_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the block with WIDTH=4. At that width it can apply every code against every pair of operands, for each combination of shifter carry, set-flags bit and stored carry. This reaches every carry-out and borrow boundary, every signed overflow edge, and every zero and negative result. Each vector is preceded by a flag-setting move that loads a chosen carry, so the carry-using forms are tried with both carry values. A final pass holds en_i low and confirms that the stored flags do not change.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic is_arith(alu_op_e op);
    return op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC, OP_SBC, OP_RSC, OP_CMP, OP_CMN};
  endfunction

  function automatic logic is_flag_only(alu_op_e op);
    return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
  endfunction
endpackage

// File: rtl/dp_alu_addsub.sv
module dp_alu_addsub
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o,
  output logic             v_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             cin;
  logic [WIDTH:0]   full;

  // subtraction is x + ~y + 1, so carry out doubles as not-borrow
  always_comb begin
    x = a_i;
    y = b_i;
    cin = 1'b0;
    unique case (op_i)
      OP_ADD, OP_CMN: begin x = a_i; y = b_i;  cin = 1'b0; end
      OP_ADC:         begin x = a_i; y = b_i;  cin = c_i;  end
      OP_SUB, OP_CMP: begin x = a_i; y = ~b_i; cin = 1'b1; end
      OP_SBC:         begin x = a_i; y = ~b_i; cin = c_i;  end
      OP_RSB:         begin x = b_i; y = ~a_i; cin = 1'b1; end
      OP_RSC:         begin x = b_i; y = ~a_i; cin = c_i;  end
      default:        begin x = a_i; y = b_i;  cin = 1'b0; end
    endcase
  end

  assign full  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  assign sum_o = full[MSB:0];
  assign c_o   = full[WIDTH];
  assign v_o   = (x[MSB] == y[MSB]) && (full[MSB] != x[MSB]);
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: res_o = a_i & b_i;
      OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
      OP_ORR:         res_o = a_i | b_i;
      OP_MOV:         res_o = b_i;
      OP_BIC:         res_o = a_i & ~b_i;
      OP_MVN:         res_o = ~b_i;
      default:        res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             upd_i,
  input  logic             arith_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             add_c_i,
  input  logic             add_v_i,
  input  logic             shift_c_i,
  output nzcv_t            flags_q_o,
  output nzcv_t            flags_d_o
);
  nzcv_t flags_q;

  always_comb begin
    flags_d_o = flags_q;
    if (upd_i) begin
      flags_d_o.n = res_i[WIDTH-1];
      flags_d_o.z = (res_i == '0);
      flags_d_o.c = arith_i ? add_c_i : shift_c_i;
      flags_d_o.v = arith_i ? add_v_i : flags_q.v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (en_i) flags_q <= flags_d_o;
  end

  assign flags_q_o = flags_q;
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             shift_c_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic [3:0]       flags_o,
  output logic [3:0]       flags_nxt_o
);
  alu_op_e          op;
  logic             arith, flag_only;
  logic [WIDTH-1:0] sum, lres, res;
  logic             add_c, add_v;
  nzcv_t            flags_q, flags_d;

  assign op        = alu_op_e'(op_i);
  assign arith     = is_arith(op);
  assign flag_only = is_flag_only(op);

  dp_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op_i (op),
    .a_i  (opa_i),
    .b_i  (opb_i),
    .c_i  (flags_q.c),
    .sum_o(sum),
    .c_o  (add_c),
    .v_o  (add_v)
  );

  dp_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op_i (op),
    .a_i  (opa_i),
    .b_i  (opb_i),
    .res_o(lres)
  );

  assign res = arith ? sum : lres;

  dp_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .upd_i    (set_flags_i | flag_only),
    .arith_i  (arith),
    .res_i    (res),
    .add_c_i  (add_c),
    .add_v_i  (add_v),
    .shift_c_i(shift_c_i),
    .flags_q_o(flags_q),
    .flags_d_o(flags_d)
  );

  assign result_o    = res;
  assign wr_en_o     = ~flag_only;
  assign flags_o     = flags_q;
  assign flags_nxt_o = flags_d;
endmodule

// File: rtl/dp_alu_chk.sv
module dp_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [3:0]       op_i,
  input logic             shift_c_i,
  input logic             set_flags_i,
  input logic [WIDTH-1:0] result_o,
  input logic             wr_en_o,
  input logic [3:0]       flags_o,
  input logic [3:0]       flags_nxt_o
);
  logic cmp_op, logic_op, upd;
  assign cmp_op   = (op_i >= 4'd8) && (op_i <= 4'd11);
  assign logic_op = !(((op_i >= 4'd2) && (op_i <= 4'd7)) || op_i == 4'd10 || op_i == 4'd11);
  assign upd      = set_flags_i || cmp_op;

  a_r3_cmp_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_op |-> !wr_en_o);
  a_r4_hold_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd |-> flags_nxt_o == flags_o);
  a_r5_nz_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd |-> (flags_nxt_o[3] == result_o[WIDTH-1]) && (flags_nxt_o[2] == (result_o == '0)));
  a_r7_logic_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (logic_op && upd) |-> flags_nxt_o[1] == shift_c_i);
  a_r9_logic_keeps_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    logic_op |-> flags_nxt_o[0] == flags_o[0]);
  a_r11_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> flags_o == $past(flags_nxt_o));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(flags_o));
endmodule

bind dp_alu dp_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .op_i       (op_i),
  .shift_c_i  (shift_c_i),
  .set_flags_i(set_flags_i),
  .result_o   (result_o),
  .wr_en_o    (wr_en_o),
  .flags_o    (flags_o),
  .flags_nxt_o(flags_nxt_o)
);

// File: tb/tb_dp_alu.sv
module tb_dp_alu;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [3:0]   op = '0;
  logic [W-1:0] opa = '0, opb = '0;
  logic         shc = 1'b0, sflg = 1'b0;
  logic [W-1:0] result;
  logic         wr_en;
  logic [3:0]   flags, flags_nxt;

  int checks = 0, bad = 0, cyc = 0;
  bit done = 1'b0;
  logic [3:0] model = '0;

  always #5 clk = ~clk;

  dp_alu #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .op_i(op), .opa_i(opa), .opb_i(opb),
    .shift_c_i(shc), .set_flags_i(sflg), .result_o(result), .wr_en_o(wr_en),
    .flags_o(flags), .flags_nxt_o(flags_nxt)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++;
      $display("FAIL watchdog R11 actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s op=%0d a=%0d b=%0d actual=%0h expected=%0h", tag, op, opa, opb, act, exp);
    end
  endtask

  function automatic int sx(int v);
    return (v >= 8) ? v - 16 : v;
  endfunction

  task automatic run_vec(int o, int a, int b, int sc, int s, int e);
    int u, sr, cin, p, q, bin, res, c, v, we, upd, n;
    bit arith, is_add;
    logic [3:0] nf;
    @(negedge clk);
    op = 4'(o); opa = W'(a); opb = W'(b); shc = sc[0]; sflg = s[0]; en = e[0];
    #1;
    arith = (o >= 2 && o <= 7) || o == 10 || o == 11;
    is_add = (o == 4 || o == 5 || o == 11);
    c = model[1]; v = model[0]; res = 0;
    if (arith && is_add) begin
      cin = (o == 5) ? c : 0;
      u = a + b + cin; res = u & 15; c = (u >= 16) ? 1 : 0;
      sr = sx(a) + sx(b) + cin; v = (sr > 7 || sr < -8) ? 1 : 0;
    end else if (arith) begin
      p = (o == 3 || o == 7) ? b : a;
      q = (o == 3 || o == 7) ? a : b;
      bin = (o == 6 || o == 7) ? 1 - c : 0;
      u = p - q - bin; res = u & 15; c = (u >= 0) ? 1 : 0;
      sr = sx(p) - sx(q) - bin; v = (sr > 7 || sr < -8) ? 1 : 0;
    end else begin
      case (o)
        0, 8:  res = a & b;
        1, 9:  res = a ^ b;
        12:    res = a | b;
        13:    res = b;
        14:    res = a & (~b & 15);
        default: res = ~b & 15;
      endcase
      c = sc;
    end
    we = (o >= 8 && o <= 11) ? 0 : 1;
    upd = (s != 0 || we == 0) ? 1 : 0;
    n = (res >= 8) ? 1 : 0;
    nf = upd ? {n[0], (res == 0), c[0], v[0]} : model;
    chk(arith ? "R1" : "R2", result, res);
    chk("R3", wr_en, we);
    if (!upd) chk("R4", flags_nxt, nf);
    else begin
      chk("R5", flags_nxt[3:2], nf[3:2]);
      chk(arith ? "R6" : "R7", flags_nxt[1], nf[1]);
      chk(arith ? "R8" : "R9", flags_nxt[0], nf[0]);
      if (we == 0 && s == 0) chk("R10", flags_nxt, nf);
    end
    @(posedge clk); #1;
    if (e != 0) model = nf;
    chk("R11", flags, model);
  endtask

  initial begin
    #12;
    chk("R11", flags, 0);  // reset state
    @(negedge clk); rst_n = 1'b1;
    // exhaustive sweep; a flag-setting MOV first loads the chosen carry
    for (int o = 0; o < 16; o++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int k = 0; k < 8; k++) begin
            run_vec(13, a, a ^ b, k & 1, 1, 1);
            run_vec(o, a, b, (k >> 1) & 1, (k >> 2) & 1, 1);
          end
    // R11: en low holds the register whatever the operation
    for (int i = 0; i < 64; i++) run_vec(i & 15, (i * 7) & 15, (i * 5 + 3) & 15, i & 1, 1, 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule